// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block holds back the completion interrupts of a transmit path and a receive path so that a host is not woken for every frame. Each direction receives a one-cycle completion strobe from its DMA engine and produces a one-cycle moderated interrupt pulse. Two timers per direction decide when that pulse is issued. A burst timer caps the time from the first unreported completion to the interrupt. A gap timer fires once the completion stream has been quiet for a programmed time. Whichever timer fires first produces the interrupt, and then both timers of that direction are stopped.

Each timer has its own control word and threshold word, written and read through a simple synchronous write port and a combinational read port. A timer counts either every core clock cycle or only the cycles in which an external microsecond tick strobe is high. If both timers of a direction are disabled, moderation is off and each completion is passed straight through as an interrupt.

Top module: `irq_moderator`

## Requirements
- R1: After reset both interrupt outputs are low and all eight configuration words read back as zero.
- R2: Register address bit 2 selects the direction (0 transmit, 1 receive), bit 1 selects the timer (0 burst, 1 gap), and bit 0 selects the word (0 control, 1 threshold). In the control word, bit 0 is enable, bit 1 is clear and bit 2 is external-tick select. The control word reads back as {select, 0, enable}. The threshold reads back as written.
- R3: A control write with the clear bit set leaves the timer disabled, with its count zeroed and the timer stopped, and it stores the tick-select bit. The clear bit itself always reads as 0. Any control write with enable low also stops the timer, so a stopped timer raises no interrupt.
- R4: When both timers of a direction are disabled, a completion sampled at a clock edge makes that direction's interrupt high for the following cycle, one cycle for each completion.
- R5: The burst timer starts at a completion when it is not running and ignores later completions. With the core-clock tick and threshold T, the interrupt is high in the cycle that follows edge c+1+T, where c is the starting edge.
- R6: The gap timer restarts from zero at every completion. With the core-clock tick and threshold T, the interrupt follows edge c+1+T after the last completion edge c, provided no further completion arrives.
- R7: The interrupt lasts one cycle. When it is issued, both timers of the direction stop and clear, and no further interrupt occurs until a new completion arrives.
- R8: With external-tick select set, a timer advances only on cycles where us_tick is high. It fires on the (T+1)-th tick after it starts.
- R9: A threshold of zero fires on the first tick after the starting completion.
- R10: The two directions are independent: activity on one never causes an interrupt on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond tick strobe, synchronous to clk |
| tx_comp | input | 1 | Transmit completion strobe |
| rx_comp | input | 1 | Receive completion strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_waddr | input | 3 | Configuration write address |
| cfg_wdata | input | THR_W | Configuration write data |
| cfg_raddr | input | 3 | Configuration read address |
| cfg_rdata | output | THR_W | Configuration read data (combinational) |
| tx_irq | output | 1 | Moderated transmit interrupt pulse |
| rx_irq | output | 1 | Moderated receive interrupt pulse |

## Verification
The bench holds completions high through the point where the burst timer fires. A design that let ongoing completions restart the burst timer would never interrupt, and one that dropped the completion arriving in the firing cycle would miss the second interrupt six cycles later. Spaced completions confirm that the gap timer measures from the last event, not the first. It also checks that a gap firing also kills a long burst timer, since a leftover burst count would cause a stray second interrupt. Zero thresholds, tick-gated counting with a sparse external strobe, and a clear issued mid-count are also checked: an off-by-one compare, counting core clocks while external tick is selected, or a clear that leaves the timer running would each show up as a pulse in the wrong cycle.

// File: rtl/imod_pkg.sv
package imod_pkg;

    // control word field positions
    localparam int CTRL_EN  = 0;
    localparam int CTRL_CLR = 1;
    localparam int CTRL_EXT = 2;
    localparam int CTRL_W   = 3;

    // configuration address layout
    localparam int ADDR_W       = 3;
    localparam int ADDR_DIR_BIT = 2;
    localparam int ADDR_TMR_BIT = 1;
    localparam int ADDR_REG_BIT = 0;

    localparam int NUM_DIR = 2;
    localparam int NUM_TMR = 2;

    typedef enum logic {
        TK_BURST = 1'b0,
        TK_IDLE  = 1'b1
    } timer_kind_e;

endpackage

// File: rtl/imod_timer.sv
module imod_timer
    import imod_pkg::*;
#(
    parameter int          THR_W = 16,
    parameter timer_kind_e KIND  = TK_BURST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              evt,
    input  logic              kill,
    input  logic              ctrl_we,
    input  logic              thr_we,
    input  logic [THR_W-1:0]  wdata,
    output logic              fire_o,
    output logic              enabled_o,
    output logic              running_o,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [THR_W-1:0]  thr_rd
);

    typedef struct packed {
        logic             en;
        logic             ext;
        logic             run;
        logic [THR_W-1:0] cnt;
        logic [THR_W-1:0] thr;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic       tick;
    logic       restart;

    always_comb begin
        tick = s_q.ext ? us_tick : 1'b1;
        if (KIND == TK_IDLE) begin
            restart = evt;
        end else begin
            restart = evt && (!s_q.run || kill);
        end
        fire_o = s_q.en && s_q.run && tick && (s_q.cnt >= s_q.thr)
                 && !((KIND == TK_IDLE) && evt);

        s_d = s_q;
        if (kill) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (s_q.run && tick) begin
            s_d.cnt = s_q.cnt + THR_W'(1);
        end
        if (restart && s_q.en) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
        end
        if (thr_we) begin
            s_d.thr = wdata;
        end
        if (ctrl_we) begin
            s_d.en  = wdata[CTRL_EN] & ~wdata[CTRL_CLR];
            s_d.ext = wdata[CTRL_EXT];
            if (wdata[CTRL_CLR] || !wdata[CTRL_EN]) begin
                s_d.run = 1'b0;
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign enabled_o = s_q.en;
    assign running_o = s_q.run;
    assign ctrl_rd   = {s_q.ext, 1'b0, s_q.en};
    assign thr_rd    = s_q.thr;

    // a disabled timer is never running
    assert_off_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |-> !s_q.run);

    // clear write zeroes and stops the timer
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[CTRL_CLR]) |=> (!s_q.en && !s_q.run && s_q.cnt == '0));

    // a running timer advances by exactly one per tick
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && tick && !kill && !ctrl_we && !restart)
        |=> (s_q.cnt == $past(s_q.cnt) + THR_W'(1)));

    generate
        if (KIND == TK_IDLE) begin : g_idle_chk
            // every completion reloads the gap timer
            assert_gap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (evt && s_q.en && !ctrl_we) |=> (s_q.run && s_q.cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/imod_channel.sv
module imod_channel
    import imod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            us_tick,
    input  logic                            evt,
    input  logic [NUM_TMR-1:0]              we_ctrl,
    input  logic [NUM_TMR-1:0]              we_thr,
    input  logic [THR_W-1:0]                wdata,
    output logic                            irq_o,
    output logic [NUM_TMR-1:0][CTRL_W-1:0]  ctrl_rd,
    output logic [NUM_TMR-1:0][THR_W-1:0]   thr_rd
);

    typedef struct packed {
        logic done;
    } chan_state_t;

    chan_state_t          c_d, c_q;
    logic [NUM_TMR-1:0]   fire;
    logic [NUM_TMR-1:0]   enabled;
    logic [NUM_TMR-1:0]   running;
    logic                 kill;
    logic                 mod_on;

    generate
        for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
            localparam timer_kind_e KIND_K = (k == 0) ? TK_BURST : TK_IDLE;
            imod_timer #(
                .THR_W (THR_W),
                .KIND  (KIND_K)
            ) u_tmr (
                .clk       (clk),
                .rst_n     (rst_n),
                .us_tick   (us_tick),
                .evt       (evt),
                .kill      (kill),
                .ctrl_we   (we_ctrl[k]),
                .thr_we    (we_thr[k]),
                .wdata     (wdata),
                .fire_o    (fire[k]),
                .enabled_o (enabled[k]),
                .running_o (running[k]),
                .ctrl_rd   (ctrl_rd[k]),
                .thr_rd    (thr_rd[k])
            );
        end
    endgenerate

    always_comb begin
        mod_on = |enabled;
        kill   = |fire;
        c_d    = c_q;
        c_d.done = mod_on ? kill : evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign irq_o = c_q.done;

    // moderation off: every completion passes straight through
    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_on && evt) |=> irq_o);

    // after a firing with no new completion, both timers are stopped
    assert_stop_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !evt) |=> (running == '0));

    // a moderated interrupt needs a timer that was running
    assert_fire_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_on && kill) |-> (running != '0));

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import imod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              tx_comp,
    input  logic              rx_comp,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_waddr,
    input  logic [THR_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [THR_W-1:0]  cfg_rdata,
    output logic              tx_irq,
    output logic              rx_irq
);

    logic [NUM_DIR-1:0]                           comp_vec;
    logic [NUM_DIR-1:0]                           irq_vec;
    logic [NUM_DIR-1:0][NUM_TMR-1:0]              we_ctrl;
    logic [NUM_DIR-1:0][NUM_TMR-1:0]              we_thr;
    logic [NUM_DIR-1:0][NUM_TMR-1:0][CTRL_W-1:0]  ctrl_all;
    logic [NUM_DIR-1:0][NUM_TMR-1:0][THR_W-1:0]   thr_all;

    assign comp_vec = {rx_comp, tx_comp};
    assign tx_irq   = irq_vec[0];
    assign rx_irq   = irq_vec[1];

    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
            for (genvar k = 0; k < NUM_TMR; k++) begin : g_dec
                logic hit;
                assign hit = cfg_we
                             && (cfg_waddr[ADDR_DIR_BIT] == 1'(d))
                             && (cfg_waddr[ADDR_TMR_BIT] == 1'(k));
                assign we_ctrl[d][k] = hit && !cfg_waddr[ADDR_REG_BIT];
                assign we_thr[d][k]  = hit &&  cfg_waddr[ADDR_REG_BIT];
            end

            imod_channel #(
                .THR_W (THR_W)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .us_tick (us_tick),
                .evt     (comp_vec[d]),
                .we_ctrl (we_ctrl[d]),
                .we_thr  (we_thr[d]),
                .wdata   (cfg_wdata),
                .irq_o   (irq_vec[d]),
                .ctrl_rd (ctrl_all[d]),
                .thr_rd  (thr_all[d])
            );
        end
    endgenerate

    always_comb begin
        if (cfg_raddr[ADDR_REG_BIT]) begin
            cfg_rdata = thr_all[cfg_raddr[ADDR_DIR_BIT]][cfg_raddr[ADDR_TMR_BIT]];
        end else begin
            cfg_rdata = THR_W'(ctrl_all[cfg_raddr[ADDR_DIR_BIT]][cfg_raddr[ADDR_TMR_BIT]]);
        end
    end

    // the clear bit never reads back as set
    assert_clr_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_raddr[ADDR_REG_BIT] |-> !cfg_rdata[CTRL_CLR]);

endmodule

// File: tb/sim_irq_moderator.sv
module sim_irq_moderator;

    localparam int THR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             us_tick = 1'b0;
    logic             tx_comp = 1'b0;
    logic             rx_comp = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_waddr = '0;
    logic [THR_W-1:0] cfg_wdata = '0;
    logic [2:0]       cfg_raddr = '0;
    logic [THR_W-1:0] cfg_rdata;
    logic             tx_irq;
    logic             rx_irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    irq_moderator #(.THR_W(THR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .tx_comp(tx_comp), .rx_comp(rx_comp),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // address: {dir, timer, word}
    localparam logic [2:0] TX_B_CTL = 3'b000, TX_B_THR = 3'b001;
    localparam logic [2:0] TX_I_CTL = 3'b010, TX_I_THR = 3'b011;
    localparam logic [2:0] RX_B_CTL = 3'b100, RX_B_THR = 3'b101;
    localparam logic [2:0] RX_I_CTL = 3'b110, RX_I_THR = 3'b111;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [THR_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [THR_W-1:0] exp);
        cfg_raddr = a;
        #1;
        check(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_comp = 1'b1;
        @(negedge clk); tx_comp = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_comp = 1'b1;
        @(negedge clk); rx_comp = 1'b0;
    endtask

    task automatic all_off();
        wr(TX_B_CTL, 16'h2); wr(TX_I_CTL, 16'h2);
        wr(RX_B_CTL, 16'h2); wr(RX_I_CTL, 16'h2);
    endtask

    task automatic t_reset();
        check("R1 tx_irq reset", 32'(tx_irq), 0);
        check("R1 rx_irq reset", 32'(rx_irq), 0);
        for (int a = 0; a < 8; a++) rd_check("R1 reg reset", 3'(a), '0);
    endtask

    task automatic t_regs();
        wr(RX_I_THR, 16'hBEEF);
        rd_check("R2 threshold readback", RX_I_THR, 16'hBEEF);
        rd_check("R2 other threshold untouched", RX_B_THR, 16'h0000);
        wr(TX_I_CTL, 16'h5);
        rd_check("R2 control readback", TX_I_CTL, 16'h0005);
        wr(TX_I_CTL, 16'h7);
        rd_check("R3 clear disables, keeps select", TX_I_CTL, 16'h0004);
        wr(TX_I_CTL, 16'h2);
        rd_check("R3 clear-only write", TX_I_CTL, 16'h0000);
        wr(RX_I_THR, 16'h0);
    endtask

    task automatic t_passthru();
        pulse_tx();
        check("R4 passthrough high", 32'(tx_irq), 1);
        check("R10 rx quiet on tx event", 32'(rx_irq), 0);
        edges(1);
        check("R4 passthrough one cycle", 32'(tx_irq), 0);
        @(negedge clk); rx_comp = 1'b1;
        @(negedge clk);
        check("R4 back-to-back first", 32'(rx_irq), 1);
        @(negedge clk); rx_comp = 1'b0;
        check("R4 back-to-back second", 32'(rx_irq), 1);
        edges(1);
        check("R4 back-to-back end", 32'(rx_irq), 0);
    endtask

    task automatic t_burst();
        logic [13:0] seen;
        wr(TX_B_THR, 16'd5);
        wr(TX_B_CTL, 16'h1);
        @(negedge clk); tx_comp = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(posedge clk); #1;
            seen[i] = tx_irq;
            if (i == 9) tx_comp = 1'b0;
        end
        // edge 0 starts; fires after edge 6, restarts there, fires after edge 12
        check("R5 burst fires under continuous completions", 32'(seen), 32'(14'b01_0000_0100_0000));
        edges(10);
        check("R7 burst quiet after last window", 32'(tx_irq), 0);
        all_off();
    endtask

    task automatic t_idle();
        logic [12:0] seen;
        wr(RX_I_THR, 16'd3);
        wr(RX_I_CTL, 16'h1);
        @(negedge clk); rx_comp = 1'b1;
        for (int i = 0; i < 13; i++) begin
            @(posedge clk); #1;
            seen[i] = rx_irq;
            rx_comp = (i == 1 || i == 3) ? 1'b1 : 1'b0;
            check("R10 tx quiet during rx traffic", 32'(tx_irq), 0);
        end
        // completions at edges 0,2,4; fire after edge 8
        check("R6 gap measured from last completion", 32'(seen), 32'(13'b0_0001_0000_0000));
        all_off();
    endtask

    task automatic t_thr0();
        int hits = 0;
        wr(TX_B_THR, 16'd0);
        wr(TX_B_CTL, 16'h1);
        pulse_tx();
        check("R9 zero threshold not immediate", 32'(tx_irq), 0);
        edges(1);
        check("R9 zero threshold first tick", 32'(tx_irq), 1);
        for (int i = 0; i < 10; i++) begin
            edges(1);
            hits += int'(tx_irq);
        end
        check("R7 single pulse then stopped", 32'(hits), 0);
        all_off();
    endtask

    task automatic t_combined();
        int hits = 0;
        wr(TX_B_THR, 16'd20); wr(TX_B_CTL, 16'h1);
        wr(TX_I_THR, 16'd2);  wr(TX_I_CTL, 16'h1);
        pulse_tx();
        edges(2);
        check("R6 gap not yet", 32'(tx_irq), 0);
        edges(1);
        check("R6 gap fires first", 32'(tx_irq), 1);
        for (int i = 0; i < 30; i++) begin
            edges(1);
            hits += int'(tx_irq);
        end
        check("R7 burst timer killed by gap firing", 32'(hits), 0);
        all_off();
    endtask

    task automatic t_ext();
        wr(RX_I_THR, 16'd1);
        wr(RX_I_CTL, 16'h5);
        pulse_rx();
        edges(10);
        check("R8 no count without ticks", 32'(rx_irq), 0);
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
        check("R8 first tick below threshold", 32'(rx_irq), 0);
        edges(5);
        check("R8 still waiting for tick", 32'(rx_irq), 0);
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
        check("R8 fires on second tick", 32'(rx_irq), 1);
        edges(1);
        check("R7 ext pulse one cycle", 32'(rx_irq), 0);
        all_off();
    endtask

    task automatic t_clear_stop();
        int hits = 0;
        wr(RX_I_THR, 16'd4);
        wr(RX_I_CTL, 16'h1);
        pulse_rx();
        edges(1);
        wr(RX_I_CTL, 16'h2);
        rd_check("R3 clear reads disabled", RX_I_CTL, 16'h0000);
        for (int i = 0; i < 12; i++) begin
            edges(1);
            hits += int'(rx_irq);
        end
        check("R3 cleared timer never fires", 32'(hits), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_passthru();
        t_burst();
        t_idle();
        t_thr0();
        t_combined();
        t_ext();
        t_clear_stop();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule